// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block brings one card port up and down in a safe order. When the host asks for a session and a card is present, it switches on the card supply. It waits for the supply-good flag, enables the I/O line and then starts the card clock. It holds the card reset low for a programmable number of card clock cycles and then releases it. Once the port is up, it stays active until one of three events occurs: a host power-down command, removal of the card, or an overload on the card supply.

Each of the three events forces an ordered shutdown at once. Reset goes low first, then the clock stops, then the I/O line is driven low, and the supply turns off last. A fixed number of timebase ticks separates each step. The sequence can start from any point of a partial activation. In that case it skips the steps whose outputs are already low, so no output rises during a shutdown. Only an overload also turns off the converter enable and latches a fault bit. While that bit is set, new activation requests are ignored. A status read clears it.

The card-detect input has a programmable polarity. It passes through a synchronizer and a tick-based debouncer before it can start a power-down. Short glitches therefore have no effect.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, vcc_en, io_en, clk_en, card_rst and fault are 0 and conv_en is 1.
- R2: An accepted activation raises vcc_en alone. It holds that pattern while vgood is 0. Once vgood is 1 it raises io_en. After exactly STEP_TICKS ticks it raises clk_en. Written as {vcc_en,io_en,clk_en,card_rst}, the pattern sequence is 0000, 1000, 1100, 1110, 1111.
- R3: card_rst rises after exactly rst_len cclk_stb pulses counted while the clock is enabled (rst_len of 1 or more). card_rst is 1 only while clk_en, io_en and vcc_en are all 1.
- R4: A deact_req pulse while active gives the pattern sequence 1111, 1110, 1100, 1000, 0000, with exactly STEP_TICKS ticks spent in each of the three middle patterns.
- R5: A power-down during a partial activation lowers only outputs that are on, in the same order, so no output rises. The supply is always the last output to turn off.
- R6: Card removal starts the same ordered power-down without setting fault. A detect change shorter than DEB_TICKS consecutive ticks has no effect.
- R7: The card counts as present when det_raw equals det_pol: with det_pol=1 a high input means present, and with det_pol=0 a low input means present.
- R8: If ovl is 1 while vcc_en is 1, fault is 1 and conv_en is 0 from the next cycle on, and the ordered power-down runs.
- R9: act_req is ignored while the card is absent or while fault is 1.
- R10: A stat_rd pulse clears fault and restores conv_en. An overload in the same cycle wins, and fault stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| cclk_stb | input | 1 | One pulse per card clock cycle |
| act_req | input | 1 | Host activation request pulse |
| deact_req | input | 1 | Host power-down request pulse |
| det_raw | input | 1 | Raw card-detect switch level |
| det_pol | input | 1 | Level of det_raw that means card present |
| ovl | input | 1 | Card supply overload flag |
| vgood | input | 1 | Card supply within range |
| stat_rd | input | 1 | Status read strobe, clears fault |
| rst_len | input | RST_W | Card clock cycles to hold reset low |
| vcc_en | output | 1 | Card supply enable |
| conv_en | output | 1 | Converter enable |
| card_rst | output | 1 | Card reset line level |
| clk_en | output | 1 | Card clock enable |
| io_en | output | 1 | Card I/O enable |
| fault | output | 1 | Latched overload status bit |

## Verification
The bench builds the block with STEP_TICKS=2, DEB_TICKS=3 and RST_W=3. With these values every reset hold length from 1 to 7 can be swept in a full activation and deactivation cycle. Each step and debounce window lasts only a few ticks, which keeps these runs short. The tick and card clock strobes run at coprime periods, so every step sees strobes at a range of phases. The bench logs each output pattern together with the ticks and strobes seen during it. It then compares that log with the expected sequence for host stop, removal, overload and both kinds of partial abort.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [2:0] {
        S_OFF,
        S_UP_VCC,
        S_UP_IO,
        S_UP_CLK,
        S_ON,
        S_DN_RST,
        S_DN_CLK,
        S_DN_IO
    } seq_state_e;
endpackage

// File: rtl/cps_detect.sv
module cps_detect #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic det_raw,
    input  logic det_pol,
    output logic present
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [CW-1:0] cnt;
    } det_t;

    det_t det_d, det_q;
    logic sample;

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[0], det_raw};
        sample     = (det_q.sync[1] == det_pol);
        if (tick) begin
            if (sample == det_q.stable) begin
                det_d.cnt = '0;
            end else if (det_q.cnt == CW'(DEB_TICKS - 1)) begin
                det_d.stable = sample;
                det_d.cnt    = '0;
            end else begin
                det_d.cnt = det_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign present = det_q.stable;
endmodule

// File: rtl/cps_fault.sv
module cps_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic ovl,
    input  logic powered,
    input  logic stat_rd,
    output logic fault,
    output logic conv_en
);
    logic fault_d, fault_q;

    always_comb begin
        fault_d = fault_q;
        if (stat_rd)         fault_d = 1'b0;
        if (ovl && powered)  fault_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    assign fault   = fault_q;
    assign conv_en = !fault_q;
endmodule

// File: rtl/cps_seq.sv
module cps_seq
    import cps_pkg::*;
#(
    parameter int STEP_TICKS = 3,
    parameter int RST_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cclk_stb,
    input  logic             act_req,
    input  logic             deact_req,
    input  logic             present,
    input  logic             ovl,
    input  logic             vgood,
    input  logic             fault,
    input  logic [RST_W-1:0] rst_len,
    output logic             vcc_en,
    output logic             io_en,
    output logic             clk_en,
    output logic             card_rst
);
    localparam int SW = $clog2(STEP_TICKS + 1);
    localparam int CW = (SW > RST_W) ? SW : RST_W;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic stop, step_done;

    always_comb begin
        seq_d     = seq_q;
        stop      = deact_req || !present || ovl;
        step_done = tick && (seq_q.cnt == CW'(STEP_TICKS - 1));
        case (seq_q.st)
            S_OFF: begin
                if (act_req && present && !fault && !ovl) begin
                    seq_d.st  = S_UP_VCC;
                    seq_d.cnt = '0;
                end
            end
            S_UP_VCC: begin
                seq_d.cnt = '0;
                if (stop)       seq_d.st = S_DN_IO;
                else if (vgood) seq_d.st = S_UP_IO;
            end
            S_UP_IO: begin
                if (stop) begin
                    seq_d.st  = S_DN_CLK;
                    seq_d.cnt = '0;
                end else if (step_done) begin
                    seq_d.st  = S_UP_CLK;
                    seq_d.cnt = '0;
                end else if (tick) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            S_UP_CLK: begin
                if (stop) begin
                    seq_d.st  = S_DN_RST;
                    seq_d.cnt = '0;
                end else if (seq_q.cnt == CW'(rst_len)) begin
                    seq_d.st  = S_ON;
                    seq_d.cnt = '0;
                end else if (cclk_stb) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            S_ON: begin
                seq_d.cnt = '0;
                if (stop) seq_d.st = S_DN_RST;
            end
            default: begin
                if (step_done) begin
                    seq_d.cnt = '0;
                    case (seq_q.st)
                        S_DN_RST: seq_d.st = S_DN_CLK;
                        S_DN_CLK: seq_d.st = S_DN_IO;
                        default:  seq_d.st = S_OFF;
                    endcase
                end else if (tick) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_OFF, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign vcc_en   = (seq_q.st != S_OFF);
    assign io_en    = (seq_q.st == S_UP_IO) || (seq_q.st == S_UP_CLK) || (seq_q.st == S_ON)
                   || (seq_q.st == S_DN_RST) || (seq_q.st == S_DN_CLK);
    assign clk_en   = (seq_q.st == S_UP_CLK) || (seq_q.st == S_ON) || (seq_q.st == S_DN_RST);
    assign card_rst = (seq_q.st == S_ON);
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq #(
    parameter int STEP_TICKS = 3,
    parameter int DEB_TICKS  = 4,
    parameter int RST_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cclk_stb,
    input  logic             act_req,
    input  logic             deact_req,
    input  logic             det_raw,
    input  logic             det_pol,
    input  logic             ovl,
    input  logic             vgood,
    input  logic             stat_rd,
    input  logic [RST_W-1:0] rst_len,
    output logic             vcc_en,
    output logic             conv_en,
    output logic             card_rst,
    output logic             clk_en,
    output logic             io_en,
    output logic             fault
);
    logic present;

    cps_detect #(.DEB_TICKS(DEB_TICKS)) i_detect (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .det_raw(det_raw), .det_pol(det_pol), .present(present)
    );

    cps_fault i_fault (
        .clk(clk), .rst_n(rst_n), .ovl(ovl), .powered(vcc_en),
        .stat_rd(stat_rd), .fault(fault), .conv_en(conv_en)
    );

    cps_seq #(.STEP_TICKS(STEP_TICKS), .RST_W(RST_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cclk_stb(cclk_stb),
        .act_req(act_req), .deact_req(deact_req), .present(present),
        .ovl(ovl), .vgood(vgood), .fault(fault), .rst_len(rst_len),
        .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst)
    );
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
    input logic clk,
    input logic rst_n,
    input logic deact_req,
    input logic ovl,
    input logic stat_rd,
    input logic vcc_en,
    input logic conv_en,
    input logic card_rst,
    input logic clk_en,
    input logic io_en,
    input logic fault
);
    p_rst_needs_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (clk_en && io_en && vcc_en));
    p_clk_needs_io_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> io_en);
    p_io_needs_vcc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> vcc_en);
    p_host_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rst && deact_req) |=> !card_rst);
    p_vcc_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> !$past(io_en));
    p_ovl_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl && vcc_en) |=> (fault && !conv_en));
    p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_en && fault) |=> !vcc_en);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(ovl && vcc_en)) |=> !fault);
endmodule

bind card_pwr_seq cps_checker i_chk (.*);

// File: tb/test_card_pwr_seq.sv
module test_card_pwr_seq;
    localparam int STEP = 2;
    localparam int DEB  = 3;
    localparam int RW   = 3;

    logic clk = 0, rst_n = 0, tick = 0, cclk_stb = 0, act_req = 0, deact_req = 0;
    logic det_raw = 1, det_pol = 1, ovl = 0, vgood = 0, stat_rd = 0;
    logic [RW-1:0] rst_len = 1;
    logic vcc_en, conv_en, card_rst, clk_en, io_en, fault;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int nlog = 0;
    logic [4:0] last_pat = 5'h1F;
    logic [3:0] pat_log [16];
    int tk_log [16];
    int cs_log [16];

    card_pwr_seq #(.STEP_TICKS(STEP), .DEB_TICKS(DEB), .RST_W(RW)) i_card_pwr_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cclk_stb(cclk_stb),
        .act_req(act_req), .deact_req(deact_req), .det_raw(det_raw), .det_pol(det_pol),
        .ovl(ovl), .vgood(vgood), .stat_rd(stat_rd), .rst_len(rst_len),
        .vcc_en(vcc_en), .conv_en(conv_en), .card_rst(card_rst), .clk_en(clk_en),
        .io_en(io_en), .fault(fault)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] pat();
        return {vcc_en, io_en, clk_en, card_rst};
    endfunction

    // pattern logger and strobe generator
    always @(negedge clk) begin
        if ({1'b0, pat()} != last_pat && nlog < 16) begin
            pat_log[nlog] = pat();
            tk_log[nlog]  = 0;
            cs_log[nlog]  = 0;
            nlog++;
            last_pat = {1'b0, pat()};
        end
        tick     = (cyc % 4 == 0);
        cclk_stb = (cyc % 3 == 1);
        if (nlog > 0) begin
            if (tick)     tk_log[nlog-1]++;
            if (cclk_stb) cs_log[nlog-1]++;
        end
        cyc++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        nlog = 0;
        last_pat = 5'h1F;
    endtask

    function automatic int seq_code();
        int c = 0;
        for (int i = 0; i < nlog; i++) c = (c << 4) | int'(pat_log[i]);
        return c;
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_act();
        @(negedge clk); act_req = 1; @(negedge clk); act_req = 0;
    endtask
    task automatic pulse_deact();
        @(negedge clk); deact_req = 1; @(negedge clk); deact_req = 0;
    endtask
    task automatic pulse_rd();
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    endtask

    task automatic bring_up(input string req);
        vgood = 1;
        clear_log();
        pulse_act();
        waitc(80);
        check(pat() == 4'hF, req, pat(), 4'hF);
    endtask

    task automatic check_down(input string req);
        check(seq_code() == 32'hFEC80, req, seq_code(), 32'hFEC80);
        if (nlog == 5)
            for (int i = 1; i < 4; i++)
                check(tk_log[i] == STEP, req, tk_log[i], STEP);
    endtask

    initial begin
        waitc(150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        waitc(3);
        check({vcc_en, io_en, clk_en, card_rst, fault, conv_en} == 6'b000001, "R1",
              {vcc_en, io_en, clk_en, card_rst, fault, conv_en}, 1);
        rst_n = 1;
        waitc(2);
        check({vcc_en, io_en, clk_en, card_rst, fault, conv_en} == 6'b000001, "R1",
              {vcc_en, io_en, clk_en, card_rst, fault, conv_en}, 1);
        waitc(40);

        // R2 R3 R4: sweep every reset hold length
        for (int rl = 1; rl < 8; rl++) begin
            rst_len = RW'(rl);
            vgood = 0;
            clear_log();
            pulse_act();
            waitc(30);
            check(pat() == 4'h8, "R2 vgood wait", pat(), 4'h8);
            vgood = 1;
            waitc(80);
            check(seq_code() == 32'h08CEF, "R2 order", seq_code(), 32'h08CEF);
            if (nlog == 5) begin
                check(tk_log[2] == STEP, "R2 io step", tk_log[2], STEP);
                check(cs_log[3] == rl, "R3 rst hold", cs_log[3], rl);
            end
            clear_log();
            pulse_deact();
            waitc(60);
            check_down("R4 host stop");
            check(fault == 0 && conv_en == 1, "R4 no fault", fault, 0);
        end

        // R5: abort from supply-only and from io stage
        rst_len = 2;
        vgood = 0;
        clear_log();
        pulse_act();
        waitc(10);
        pulse_deact();
        waitc(40);
        check(seq_code() == 32'h080, "R5 abort vcc", seq_code(), 32'h080);
        vgood = 1;
        clear_log();
        pulse_act();
        for (int i = 0; i < 50 && !(io_en && !clk_en); i++) @(negedge clk);
        deact_req = 1; @(negedge clk); deact_req = 0;
        waitc(40);
        check(seq_code() == 32'h08C80, "R5 abort io", seq_code(), 32'h08C80);

        // R6: glitch ignored, removal powers down without fault
        bring_up("R6 up");
        det_raw = 0; waitc(2); det_raw = 1;
        waitc(60);
        check(pat() == 4'hF, "R6 glitch", pat(), 4'hF);
        clear_log();
        det_raw = 0;
        waitc(100);
        check_down("R6 removal");
        check(fault == 0, "R6 fault", fault, 0);

        // R9: absent card blocks activation
        pulse_act();
        waitc(40);
        check(vcc_en == 0, "R9 absent", vcc_en, 0);

        // R7: inverted polarity
        det_pol = 0; det_raw = 1;
        waitc(40);
        pulse_act();
        waitc(40);
        check(vcc_en == 0, "R7 pol0 high absent", vcc_en, 0);
        det_raw = 0;
        waitc(40);
        bring_up("R7 pol0 low present");
        pulse_deact();
        waitc(60);
        det_pol = 1; det_raw = 1;
        waitc(40);

        // R8: overload
        bring_up("R8 up");
        clear_log();
        @(negedge clk); ovl = 1; @(negedge clk); ovl = 0;
        check(fault == 1 && conv_en == 0, "R8 latch", {fault, conv_en}, 2);
        waitc(60);
        check_down("R8 sequence");
        check(fault == 1, "R8 hold", fault, 1);

        // R9: fault blocks activation
        pulse_act();
        waitc(40);
        check(vcc_en == 0, "R9 fault block", vcc_en, 0);

        // R10: clear, then set-wins
        pulse_rd();
        check(fault == 0 && conv_en == 1, "R10 clear", {fault, conv_en}, 1);
        bring_up("R10 restart");
        @(negedge clk); ovl = 1; stat_rd = 1; @(negedge clk); ovl = 0; stat_rd = 0;
        check(fault == 1, "R10 set wins", fault, 1);
        waitc(60);
        pulse_rd();
        check(fault == 0, "R10 final clear", fault, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule